// File: doc/BRIEF.md
# Endian-Configurable Load/Store Aligner

This block sits between a 32-bit processor core and a data memory organised in 32-bit words. The core presents a byte address, an access size and store data. The block turns that into a word address, four byte-lane enables and write data placed on the correct lanes. When a load returns, it picks the addressed lanes out of the memory word, moves them to the low end of the result and fills the upper bits with zeros.

The byte order is captured from a strap input while reset is held, and it stays fixed until the next reset. In little-endian order the lowest-addressed byte lives in bits 7:0 of a word. In big-endian order it lives in bits 31:24.

Halfword and word accesses must be naturally aligned. An access that breaks this rule raises a single-cycle fault and never reaches memory. The request path has one register stage. A load result is ready one cycle after the memory read is issued, which matches a memory with a one-cycle synchronous read.

Top module: `lsa_aligner`

## Requirements
- R1: While `rst` is high, `endian_big_in` is captured (1 = big-endian, 0 = little-endian). In the first cycle after reset, `mem_valid`, `fault` and `rsp_valid` are all 0.
- R2: Changing `endian_big_in` after reset has no effect on lane placement or on load extraction until the next reset.
- R3: Size codes are 2'b00 byte, 2'b01 halfword, 2'b10 word and 2'b11 reserved. One cycle after an aligned request, `mem_valid` is 1, `mem_waddr` equals `req_addr[31:2]` and `mem_write` equals `req_write`.
- R4: A request is faulted when it is a halfword with `req_addr[0]`=1, a word with `req_addr[1:0]`≠0, or uses the reserved size. One cycle later a faulted request drives `fault`=1 for exactly one cycle, with `mem_valid`=0 and `mem_be`=0.
- R5: In little-endian order, a byte at offset o uses lane o. A halfword uses lanes 1:0 at offset 0 and lanes 3:2 at offset 2. A word uses all four lanes. The value's least significant byte goes to the lowest address, and data on lanes that are not enabled is zero.
- R6: In big-endian order, a byte at offset o uses lane 3−o, so offset 0 maps to bits 31:24. A halfword uses bits 31:16 at offset 0 and bits 15:0 at offset 2. The value's most significant byte goes to the lowest address, and a word keeps its value unchanged.
- R7: For a read issued in cycle t, `rsp_valid` is 1 in cycle t+1. `rsp_data` then holds the addressed bytes in the order set by R5 or R6, zero-extended to 32 bits.
- R8: Writes and faulted requests never produce `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| endian_big_in | input | 1 | Byte-order strap, sampled during reset |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store value, right-aligned |
| mem_valid | output | 1 | Memory access strobe |
| mem_write | output | 1 | Memory write select |
| mem_waddr | output | 30 | Word address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_rdata | input | 32 | Memory word, valid one cycle after a read |
| rsp_valid | output | 1 | Load result strobe |
| rsp_data | output | 32 | Zero-extended load result |
| fault | output | 1 | Alignment fault pulse |

## Verification
The stimulus covers every size at every byte offset. It includes stores followed by loads of a different width over the same bytes, so that a lane swap or a wrong shift shows up as a wrong value rather than passing unnoticed. The same sequence runs once in each byte order. This separates lane mirroring from plain shifting, and separates halfword lane selection at offset 0 from offset 2. Misaligned halfwords, misaligned words and the reserved size are mixed in with good accesses, which shows that a fault suppresses only its own access. Toggling the strap after reset, then storing and loading, shows that the order captured at reset is the one in use.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned LANES   = DATA_W / 8;
    localparam int unsigned OFS_W   = $clog2(LANES);
    localparam int unsigned WADDR_W = ADDR_W - OFS_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    // Lane bookkeeping carried alongside an access
    typedef struct packed {
        logic [OFS_W-1:0] shift;
        acc_size_e        size;
    } lane_ctx_t;

    function automatic int unsigned size_lanes(acc_size_e s);
        case (s)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            SZ_WORD: return LANES;
            default: return 0;
        endcase
    endfunction

    function automatic logic is_misaligned(acc_size_e s, logic [OFS_W-1:0] ofs);
        case (s)
            SZ_BYTE: return 1'b0;
            SZ_HALF: return ofs[0];
            SZ_WORD: return |ofs;
            default: return 1'b1;
        endcase
    endfunction

    // Lowest lane occupied by an aligned access
    function automatic logic [OFS_W-1:0] lane_shift(acc_size_e s, logic [OFS_W-1:0] ofs,
                                                    logic big);
        int unsigned t;
        if (big) t = LANES - size_lanes(s) - int'(ofs);
        else     t = int'(ofs);
        return t[OFS_W-1:0];
    endfunction

    function automatic logic [LANES-1:0] size_mask(acc_size_e s);
        logic [LANES-1:0] m;
        m = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i < int'(size_lanes(s))) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/lsa_store_lanes.sv
module lsa_store_lanes
    import lsa_pkg::*;
(
    input  acc_size_e         size,
    input  logic [OFS_W-1:0]  shift,
    input  logic [DATA_W-1:0] data_in,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] data_out
);
    logic [DATA_W-1:0] shifted;
    logic [LANES-1:0]  lane_en;

    always_comb begin
        lane_en = size_mask(size) << shift;
        shifted = data_in << {shift, 3'b000};
    end

    assign be = lane_en;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign data_out[8*g +: 8] = lane_en[g] ? shifted[8*g +: 8] : 8'h00;
    end
endmodule

// File: rtl/lsa_load_lanes.sv
module lsa_load_lanes
    import lsa_pkg::*;
(
    input  lane_ctx_t         ctx,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] data_out
);
    logic [DATA_W-1:0] shifted;
    logic [LANES-1:0]  keep;

    always_comb begin
        shifted = word_in >> {ctx.shift, 3'b000};
        keep    = size_mask(ctx.size);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign data_out[8*g +: 8] = keep[g] ? shifted[8*g +: 8] : 8'h00;
    end
endmodule

// File: rtl/lsa_req_stage.sv
module lsa_req_stage
    import lsa_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               big,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  acc_size_e          req_size,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               mem_valid,
    output logic               mem_write,
    output logic [WADDR_W-1:0] mem_waddr,
    output logic [LANES-1:0]   mem_be,
    output logic [DATA_W-1:0]  mem_wdata,
    output lane_ctx_t          mem_ctx,
    output logic               fault
);
    logic [OFS_W-1:0]  ofs;
    logic              bad;
    logic [OFS_W-1:0]  shift_c;
    logic [LANES-1:0]  be_c;
    logic [DATA_W-1:0] wd_c;

    always_comb begin
        ofs     = req_addr[OFS_W-1:0];
        bad     = is_misaligned(req_size, ofs);
        shift_c = lane_shift(req_size, ofs, big);
    end

    lsa_store_lanes u_store (
        .size     (req_size),
        .shift    (shift_c),
        .data_in  (req_wdata),
        .be       (be_c),
        .data_out (wd_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_valid <= 1'b0;
            mem_write <= 1'b0;
            mem_waddr <= '0;
            mem_be    <= '0;
            mem_wdata <= '0;
            mem_ctx   <= '0;
            fault     <= 1'b0;
        end else begin
            mem_valid <= req_valid && !bad;
            fault     <= req_valid && bad;
            if (req_valid && !bad) begin
                mem_write <= req_write;
                mem_waddr <= req_addr[ADDR_W-1:OFS_W];
                mem_be    <= be_c;
                mem_wdata <= req_write ? wd_c : '0;
                mem_ctx   <= '{shift: shift_c, size: req_size};
            end else begin
                mem_be    <= '0;
                mem_write <= 1'b0;
            end
        end
    end

    p_fault_blocks_access_r4: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!mem_valid && mem_be == '0));

    p_misaligned_faults_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_misaligned(req_size, req_addr[OFS_W-1:0])) |=> fault);

    p_aligned_issues_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !is_misaligned(req_size, req_addr[OFS_W-1:0]))
        |=> (mem_valid && mem_waddr == $past(req_addr[ADDR_W-1:OFS_W])));
endmodule

// File: rtl/lsa_aligner.sv
module lsa_aligner
    import lsa_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               endian_big_in,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_size,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               mem_valid,
    output logic               mem_write,
    output logic [WADDR_W-1:0] mem_waddr,
    output logic [LANES-1:0]   mem_be,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               fault
);
    logic      endian_q;
    lane_ctx_t issue_ctx;
    lane_ctx_t rd_ctx;

    // Byte order is only ever loaded while reset is held
    always_ff @(posedge clk) begin
        if (rst) endian_q <= endian_big_in;
    end

    lsa_req_stage u_req (
        .clk       (clk),
        .rst       (rst),
        .big       (endian_q),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_size  (acc_size_e'(req_size)),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .mem_valid (mem_valid),
        .mem_write (mem_write),
        .mem_waddr (mem_waddr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .mem_ctx   (issue_ctx),
        .fault     (fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rd_ctx    <= '0;
        end else begin
            rsp_valid <= mem_valid && !mem_write;
            if (mem_valid && !mem_write) rd_ctx <= issue_ctx;
        end
    end

    lsa_load_lanes u_load (
        .ctx      (rd_ctx),
        .word_in  (mem_rdata),
        .data_out (rsp_data)
    );

    p_endian_held_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(endian_q));

    p_lane_count_r5: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                       || $countones(mem_be) == LANES));

    p_read_returns_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_write) |=> rsp_valid);

    p_no_rsp_r8: assert property (@(posedge clk) disable iff (rst)
        ((mem_valid && mem_write) || fault) |=> !rsp_valid);

    p_byte_zero_ext_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rd_ctx.size == SZ_BYTE) |-> (rsp_data[DATA_W-1:8] == '0));
endmodule

// File: tb/lsa_aligner_test.sv
module lsa_aligner_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        endian_big_in = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        mem_valid, mem_write, rsp_valid, fault;
    logic [29:0] mem_waddr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, rsp_data;
    logic [31:0] mem_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit big_ref = 0;
    bit want_no_rsp = 0;

    typedef struct {
        bit          flt;
        bit          wr;
        logic [29:0] wa;
        logic [3:0]  be;
        logic [31:0] wd;
        string       tag;
    } mexp_t;

    mexp_t       mq[$];
    logic [31:0] rq[$];
    logic [7:0]  bmem [64];
    logic [31:0] wmem [16];

    always #5 clk = ~clk;

    lsa_aligner uut (
        .clk(clk), .rst(rst), .endian_big_in(endian_big_in),
        .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
        .req_write(req_write), .req_wdata(req_wdata),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_waddr(mem_waddr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .fault(fault)
    );

    // Word memory with a one-cycle read
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) wmem[i] <= '0;
            mem_rdata <= '0;
        end else if (mem_valid) begin
            if (mem_write) begin
                for (int l = 0; l < 4; l++)
                    if (mem_be[l]) wmem[mem_waddr[3:0]][8*l +: 8] <= mem_wdata[8*l +: 8];
            end else begin
                mem_rdata <= wmem[mem_waddr[3:0]];
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare outputs against scoreboard queues
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (want_no_rsp) begin
                chk("R8 no response", {31'd0, rsp_valid}, 32'd0);
                want_no_rsp = 0;
            end else if (rsp_valid) begin
                if (rq.size() == 0) chk("R8 unexpected response", 32'd1, 32'd0);
                else chk("R7 load data", rsp_data, rq.pop_front());
            end
            if (mem_valid || fault) begin
                if (mq.size() == 0) begin
                    chk("R3 unexpected access", 32'd1, 32'd0);
                end else begin
                    mexp_t e;
                    e = mq.pop_front();
                    if (e.flt) begin
                        chk("R4 fault", {30'd0, fault, mem_valid}, 32'd2);
                        chk("R4 no lanes", {28'd0, mem_be}, 32'd0);
                        want_no_rsp = 1;
                    end else begin
                        chk("R3 addr", {2'b00, mem_waddr}, {2'b00, e.wa});
                        chk("R3 dir", {31'd0, mem_write}, {31'd0, e.wr});
                        if (e.wr) begin
                            chk({e.tag, " be"}, {28'd0, mem_be}, {28'd0, e.be});
                            chk({e.tag, " wdata"}, mem_wdata, e.wd);
                            want_no_rsp = 1;
                        end else begin
                            chk({e.tag, " read be"}, {28'd0, mem_be}, {28'd0, e.be});
                        end
                    end
                end
            end
        end
    end

    // Driver: byte-level model computes expected items, then issues the request
    task automatic acc(bit wr, logic [1:0] sz, logic [31:0] a, logic [31:0] d);
        mexp_t e;
        int n;
        logic [31:0] r;
        n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 0;
        e.flt = (n == 0) || (n == 2 && a[0]) || (n == 4 && a[1:0] != 2'b00);
        e.wr = wr;
        e.wa = a[31:2];
        e.be = '0;
        e.wd = '0;
        e.tag = big_ref ? "R6" : "R5";
        r = '0;
        if (!e.flt) begin
            for (int i = 0; i < n; i++) begin
                logic [31:0] ba;
                int lane;
                int vi;
                ba = a + i;
                lane = big_ref ? 3 - int'(ba[1:0]) : int'(ba[1:0]);
                vi = big_ref ? (n - 1 - i) : i;
                e.be[lane] = 1'b1;
                if (wr) begin
                    e.wd[8*lane +: 8] = d[8*vi +: 8];
                    bmem[ba[5:0]] = d[8*vi +: 8];
                end else begin
                    r[8*vi +: 8] = bmem[ba[5:0]];
                end
            end
            if (!wr) rq.push_back(r);
        end
        mq.push_back(e);
        req_valid = 1'b1;
        req_write = wr;
        req_size = sz;
        req_addr = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_reset(bit big);
        endian_big_in = big;
        big_ref = big;
        rst = 1'b1;
        for (int i = 0; i < 64; i++) bmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset idle", {29'd0, mem_valid, fault, rsp_valid}, 32'd0);
    endtask

    task automatic pattern(logic [31:0] hi);
        acc(1, 2'b10, hi | 32'h0, 32'h11223344);
        acc(0, 2'b10, hi | 32'h0, 0);
        for (int o = 0; o < 4; o++) acc(0, 2'b00, hi | o, 0);
        acc(0, 2'b01, hi | 32'h0, 0);
        acc(0, 2'b01, hi | 32'h2, 0);
        acc(1, 2'b00, hi | 32'h5, 32'hFFFF_FFAB);
        acc(1, 2'b00, hi | 32'h4, 32'h0000_0012);
        acc(1, 2'b01, hi | 32'h6, 32'h1234_BEEF);
        acc(0, 2'b10, hi | 32'h4, 0);
        acc(1, 2'b01, hi | 32'h1, 32'h5555);
        acc(0, 2'b10, hi | 32'h2, 0);
        acc(1, 2'b10, hi | 32'h3, 32'h77);
        acc(0, 2'b11, hi | 32'h0, 0);
        acc(0, 2'b01, hi | 32'h6, 0);
        acc(1, 2'b01, hi | 32'h8, 32'hCAFE);
        acc(1, 2'b01, hi | 32'hA, 32'hD00D);
        acc(0, 2'b10, hi | 32'h8, 0);
        for (int o = 8; o < 12; o++) acc(0, 2'b00, hi | o, 0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        do_reset(1'b0);
        pattern(32'h0);
        pattern(32'h1000_0020);
        // R2: strap change after reset must not alter byte order
        endian_big_in = 1'b1;
        acc(1, 2'b00, 32'h0000_000C, 32'h9A);
        acc(1, 2'b01, 32'h0000_000E, 32'h3C5A);
        acc(0, 2'b10, 32'h0000_000C, 0);
        repeat (4) @(negedge clk);
        do_reset(1'b1);
        pattern(32'h0);
        pattern(32'h8000_0010);
        endian_big_in = 1'b0;
        acc(1, 2'b00, 32'h0000_000D, 32'h61);
        acc(0, 2'b10, 32'h0000_000C, 0);
        acc(0, 2'b01, 32'h0000_000C, 0);
        repeat (4) @(negedge clk);
        chk("R7 queues drained", mq.size() + rq.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule